// File: doc/BRIEF.md
# Parallel Register Port with GPIO Fallback

This block is the host-side register port of a video encoder. A host processor reaches a small register file over an 8-bit bus using three active-low controls: a read strobe, a write strobe and an address enable. The bus is bidirectional at the pad. Here it is split into an input vector, an output vector and a per-bit output enable, which the pad ring combines. A write cycle with the address enable low loads an internal pointer. Later read and write cycles with the address enable high then access the register that the pointer selects. The strobes are sampled by the system clock through two-stage synchronizers, and a write takes effect when the write strobe rises.

The port's mode is chosen while reset is held. If the read and write strobes are both low during reset, the port switches to serial-control mode. In that mode the strobes are ignored, and a separate word-wide access port, driven by an external serial slave, reads and writes the same register file. The 8 bus pins then act as general-purpose I/O. A direction register decides, bit by bit, whether each pin drives or listens. Pin levels are captured into the I/O data register whenever that register is accessed.

A read-only identification register returns a fixed value. Reset clears the pointer and every writable register.

Top module: `hostport_gpio`

## Requirements
- R1: A write-strobe cycle with `ae_n` low (address cycle) loads the register pointer from `bus_in`; the value on `bus_in` while `wr_n` rises is the one taken.
- R2: A write-strobe cycle with `ae_n` high (data cycle) writes `bus_in` into the register the pointer selects. Plain storage registers occupy addresses 0x00 to 0x0F, except the special addresses named in R4, R6 and R7.
- R3: In parallel mode, `bus_oe` is 0xFF and `bus_out` carries the selected register while `rd_n` is low and `ae_n` is high, each seen three clock edges after the pin change. At every other time `bus_oe` is 0x00.
- R4: Address 0x0F is read-only and always reads 0x04; writes to it have no effect.
- R5: If `rd_n` and `wr_n` are both low while `rst` is high, the port leaves reset in GPIO mode. Otherwise it leaves reset in parallel mode. The mode does not change outside reset.
- R6: In GPIO mode, the direction register at address 0x0B drives `bus_oe` (bit = 1 means output), and `bus_out` shows the I/O data register at address 0x0A, both one clock after the register changes.
- R7: In GPIO mode, each serial read or write of address 0x0A captures the synchronized pin levels into the input bits (direction 0) of the I/O data register. A write changes only the output bits, a read returns the merged value, and without such an access the register keeps its value.
- R8: While `rst` is high, all strobe and serial accesses are ignored and `bus_oe`, `bus_out` and `ser_rdata` are 0. Reset sets the pointer and all writable registers to 0x00.
- R9: In GPIO mode, activity on `rd_n`, `wr_n` and `ae_n` changes neither the pointer nor any register, and drives nothing onto the bus.
- R10: The serial port is active only in GPIO mode. `ser_rdata` updates on the clock edge that samples `ser_re`. Addresses from 0x10 upward read 0x00 and ignore writes, on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; mode is sampled while high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ae_n | input | 1 | Address enable, active low |
| bus_in | input | 8 | Bus pins as seen from the pads |
| bus_out | output | 8 | Value driven onto the bus pins |
| bus_oe | output | 8 | Per-pin output enable (1 = drive) |
| ser_we | input | 1 | Serial-side register write, one cycle |
| ser_re | input | 1 | Serial-side register read, one cycle |
| ser_addr | input | 8 | Serial-side register address |
| ser_wdata | input | 8 | Serial-side write data |
| ser_rdata | output | 8 | Serial-side read data, registered |

## Verification
On every cycle, the assertions check these properties: the bus driver in parallel mode is all-or-nothing and turns on only after a synchronized read with the address enable high; the mode and the pointer stay frozen where required; the identification register reads back its fixed value; and a direction write reaches the output enables two clocks later. The bench scenarios cover the rest. These are the pointer-then-data sequence across the whole address range, the rule that a write to the read-only address has no effect, the defaults after a reset with traffic during it, the strobes being ignored in GPIO mode, and the pin-capture arithmetic for several direction masks and pin patterns.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
  typedef enum logic {
    MODE_PARALLEL = 1'b0,
    MODE_GPIO     = 1'b1
  } port_mode_e;

  function automatic logic [7:0] merge_pins(input logic [7:0] held,
                                            input logic [7:0] pins,
                                            input logic [7:0] dir);
    return (held & dir) | (pins & ~dir);
  endfunction
endpackage

// File: rtl/hpg_sync.sv
module hpg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
      q_d  <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
      q_d  <= q;
    end
  end
endmodule

// File: rtl/hpg_regs.sv
module hpg_regs #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int NREG = 16,
  parameter logic [AW-1:0] GPIO_ADDR = 8'h0A,
  parameter logic [AW-1:0] DIR_ADDR  = 8'h0B,
  parameter logic [AW-1:0] ID_ADDR   = 8'h0F,
  parameter logic [DW-1:0] ID_VAL    = 8'h04
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          touch,
  input  logic          merge_en,
  input  logic [DW-1:0] pins,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] gpio_q
);
  localparam int IDXW = $clog2(NREG);
  localparam logic [AW-1:0] NREG_A = AW'(NREG);

  logic [DW-1:0] mem [NREG];
  logic          in_file;
  logic [DW-1:0] merged;

  assign in_file = (addr < NREG_A);
  assign merged  = (dir_q & gpio_q) | (pins & ~dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      dir_q  <= '0;
      gpio_q <= '0;
    end else if (we) begin
      if (addr == DIR_ADDR) begin
        dir_q <= wdata;
      end else if (addr == GPIO_ADDR) begin
        gpio_q <= touch ? ((wdata & dir_q) | (pins & ~dir_q)) : wdata;
      end else if (addr != ID_ADDR && in_file) begin
        mem[addr[IDXW-1:0]] <= wdata;
      end
    end else if (touch) begin
      gpio_q <= merged;
    end
  end

  always_comb begin
    if (addr == ID_ADDR)        rdata = ID_VAL;
    else if (addr == DIR_ADDR)  rdata = dir_q;
    else if (addr == GPIO_ADDR) rdata = merge_en ? merged : gpio_q;
    else if (in_file)           rdata = mem[addr[IDXW-1:0]];
    else                        rdata = '0;
  end
endmodule

// File: rtl/hostport_gpio.sv
module hostport_gpio
  import hpg_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int NREG = 16,
  parameter logic [AW-1:0] GPIO_ADDR = 8'h0A,
  parameter logic [AW-1:0] DIR_ADDR  = 8'h0B,
  parameter logic [AW-1:0] ID_ADDR   = 8'h0F,
  parameter logic [DW-1:0] ID_VAL    = 8'h04
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ae_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] bus_oe,
  input  logic          ser_we,
  input  logic          ser_re,
  input  logic [AW-1:0] ser_addr,
  input  logic [DW-1:0] ser_wdata,
  output logic [DW-1:0] ser_rdata
);
  port_mode_e    mode_q;
  logic          ser_mode;
  logic [2:0]    strb_s, strb_d;
  logic          rd_s, wr_s, ae_s, wr_d, ae_d;
  logic [DW-1:0] dat_s, dat_d;
  logic [AW-1:0] ptr_q;
  logic          wr_rise, rd_cyc;
  logic          rf_we, rf_touch;
  logic [AW-1:0] rf_addr;
  logic [DW-1:0] rf_wdata, rf_rdata, dir_q, gpio_q;

  hpg_sync #(.W(3), .RST_VAL(3'b111)) u_strb_sync (
    .clk(clk), .rst(rst), .d({rd_n, wr_n, ae_n}), .q(strb_s), .q_d(strb_d)
  );

  hpg_sync #(.W(DW), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst(rst), .d(bus_in), .q(dat_s), .q_d(dat_d)
  );

  assign {rd_s, wr_s, ae_s} = strb_s;
  assign wr_d = strb_d[1];
  assign ae_d = strb_d[0];

  always_ff @(posedge clk) begin
    if (rst) mode_q <= (!rd_n && !wr_n) ? MODE_GPIO : MODE_PARALLEL;
  end
  assign ser_mode = (mode_q == MODE_GPIO);

  assign wr_rise = !ser_mode && wr_s && !wr_d;
  assign rd_cyc  = !ser_mode && !rd_s && ae_s;

  always_ff @(posedge clk) begin
    if (rst)                  ptr_q <= '0;
    else if (wr_rise && !ae_d) ptr_q <= AW'(dat_d);
  end

  assign rf_we    = ser_mode ? ser_we : (wr_rise && ae_d);
  assign rf_addr  = ser_mode ? ser_addr : ptr_q;
  assign rf_wdata = ser_mode ? ser_wdata : dat_d;
  assign rf_touch = ser_mode && (ser_we || ser_re) && (ser_addr == GPIO_ADDR);

  hpg_regs #(
    .DW(DW), .AW(AW), .NREG(NREG), .GPIO_ADDR(GPIO_ADDR),
    .DIR_ADDR(DIR_ADDR), .ID_ADDR(ID_ADDR), .ID_VAL(ID_VAL)
  ) u_regs (
    .clk(clk), .rst(rst), .we(rf_we), .addr(rf_addr), .wdata(rf_wdata),
    .touch(rf_touch), .merge_en(ser_mode), .pins(dat_s),
    .rdata(rf_rdata), .dir_q(dir_q), .gpio_q(gpio_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out   <= '0;
      bus_oe    <= '0;
      ser_rdata <= '0;
    end else if (ser_mode) begin
      bus_out <= gpio_q;
      bus_oe  <= dir_q;
      if (ser_re) ser_rdata <= rf_rdata;
    end else begin
      bus_oe  <= rd_cyc ? '1 : '0;
      bus_out <= rd_cyc ? rf_rdata : '0;
    end
  end
endmodule

// File: rtl/hostport_gpio_chk.sv
module hostport_gpio_chk #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] DIR_ADDR = 8'h0B,
  parameter logic [AW-1:0] ID_ADDR  = 8'h0F,
  parameter logic [DW-1:0] ID_VAL   = 8'h04
) (
  input logic          clk,
  input logic          rst,
  input logic          ser,
  input logic          rd_s,
  input logic          ae_s,
  input logic [AW-1:0] ptr,
  input logic [DW-1:0] bus_oe,
  input logic          ser_we,
  input logic          ser_re,
  input logic [AW-1:0] ser_addr,
  input logic [DW-1:0] ser_wdata,
  input logic [DW-1:0] ser_rdata
);
  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    (!ser && bus_oe != '0) |-> $past(!rd_s && ae_s)); // R3
  AST_OE_WHOLE_BUS: assert property (@(posedge clk) disable iff (rst)
    !ser |-> (bus_oe == '0 || bus_oe == '1)); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) == 1'b0) |-> $stable(ser)); // R5
  AST_ID_READBACK: assert property (@(posedge clk) disable iff (rst)
    (ser && ser_re && ser_addr == ID_ADDR) |=> (ser_rdata == ID_VAL)); // R4
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
    (ser && ser_we && ser_addr == DIR_ADDR) |=> ##1 (bus_oe == $past(ser_wdata, 2))); // R6
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ser |=> $stable(ptr)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (bus_oe == '0 && ser_rdata == '0)); // R8
endmodule

bind hostport_gpio hostport_gpio_chk #(
  .DW(DW), .AW(AW), .DIR_ADDR(DIR_ADDR), .ID_ADDR(ID_ADDR), .ID_VAL(ID_VAL)
) chk_i (
  .clk(clk), .rst(rst), .ser(ser_mode), .rd_s(rd_s), .ae_s(ae_s),
  .ptr(ptr_q), .bus_oe(bus_oe), .ser_we(ser_we), .ser_re(ser_re),
  .ser_addr(ser_addr), .ser_wdata(ser_wdata), .ser_rdata(ser_rdata)
);

// File: tb/hostport_gpio_tb_top.sv
module hostport_gpio_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_n = 1'b1, wr_n = 1'b1, ae_n = 1'b1;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out, bus_oe, ser_rdata;
  logic       ser_we = 1'b0, ser_re = 1'b0;
  logic [7:0] ser_addr = '0, ser_wdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hostport_gpio dut_i (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .ae_n(ae_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ser_we(ser_we), .ser_re(ser_re), .ser_addr(ser_addr),
    .ser_wdata(ser_wdata), .ser_rdata(ser_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic rdl, input logic wrl);
    @(negedge clk);
    rst = 1'b1; rd_n = rdl; wr_n = wrl; ae_n = 1'b1;
    cycles(4);
    rst = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    cycles(4);
  endtask

  task automatic par_write(input logic ae, input logic [7:0] d);
    @(negedge clk);
    ae_n = ae; bus_in = d; wr_n = 1'b0;
    cycles(3);
    wr_n = 1'b1;
    cycles(4);
    ae_n = 1'b1;
  endtask

  task automatic par_read(input string req, input logic [7:0] exp);
    @(negedge clk);
    ae_n = 1'b1; rd_n = 1'b0;
    cycles(4);
    check(req, bus_oe, 8'hFF);
    check(req, bus_out, exp);
    rd_n = 1'b1;
    cycles(4);
    check({req, " released"}, bus_oe, 8'h00);
  endtask

  task automatic ser_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ser_we = 1'b1; ser_addr = a; ser_wdata = d;
    @(negedge clk);
    ser_we = 1'b0;
  endtask

  task automatic ser_read(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    ser_re = 1'b1; ser_addr = a;
    @(negedge clk);
    ser_re = 1'b0;
    check(req, ser_rdata, exp);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) + 3);
  endfunction

  initial begin
    // R8 reset state
    do_reset(1'b1, 1'b1);
    check("R8 oe after reset", bus_oe, 8'h00);
    check("R8 out after reset", bus_out, 8'h00);
    check("R8 ser_rdata after reset", ser_rdata, 8'h00);

    // R1 R2 R4: write every in-file address, then read back
    for (int a = 0; a < 16; a++) begin
      par_write(1'b0, 8'(a));
      par_write(1'b1, pat(a));
    end
    for (int a = 0; a < 16; a++) begin
      par_write(1'b0, 8'(a));
      par_read((a == 15) ? "R4 id read" : "R1 R2 R3 readback",
               (a == 15) ? 8'h04 : pat(a));
    end

    // R10 unmapped address in parallel mode
    par_write(1'b0, 8'h40);
    par_write(1'b1, 8'h99);
    par_read("R10 unmapped", 8'h00);

    // R8 traffic during reset ignored, defaults restored
    @(negedge clk);
    rst = 1'b1;
    ae_n = 1'b0; bus_in = 8'h02; wr_n = 1'b0; cycles(3); wr_n = 1'b1; cycles(3);
    ae_n = 1'b1; bus_in = 8'hEE; wr_n = 1'b0; cycles(3); wr_n = 1'b1; cycles(3);
    rst = 1'b0;
    cycles(4);
    par_read("R8 ptr default", 8'h00);
    par_write(1'b0, 8'h02);
    par_read("R8 reg default", 8'h00);

    // R5 only read strobe low in reset -> parallel mode
    do_reset(1'b0, 1'b1);
    par_write(1'b0, 8'h0F);
    par_read("R5 parallel kept", 8'h04);

    // R5 both strobes low -> GPIO mode
    do_reset(1'b0, 1'b0);
    bus_in = 8'h00;
    cycles(3);
    ser_read("R5 gpio mode id", 8'h0F, 8'h04);
    check("R6 default dir", bus_oe, 8'h00);

    // R9 strobes ignored in GPIO mode
    par_write(1'b0, 8'h03);
    par_write(1'b1, 8'h77);
    rd_n = 1'b0; cycles(4);
    check("R9 no drive on read strobe", bus_oe, 8'h00);
    rd_n = 1'b1;
    ser_read("R9 reg 3 untouched", 8'h03, 8'h00);
    ser_read("R9 reg 0 untouched", 8'h00, 8'h00);

    // R10 serial port access
    ser_write(8'h05, 8'h5C);
    ser_read("R10 serial readback", 8'h05, 8'h5C);
    ser_write(8'h0F, 8'hAA);
    ser_read("R4 id write ignored", 8'h0F, 8'h04);
    ser_write(8'h40, 8'h12);
    ser_read("R10 serial unmapped", 8'h40, 8'h00);

    // R6 R7 sweep over direction masks and pin patterns
    for (int k = 0; k < 8; k++) begin
      logic [7:0] dir, w, p1, p2, p3, g, g2;
      dir = 8'(k * 37) ^ ((k[0]) ? 8'hF0 : 8'h0F);
      if (k == 6) dir = 8'h00;
      if (k == 7) dir = 8'hFF;
      w  = 8'(k * 53 + 17);
      p1 = 8'(k * 91 + 7);
      p2 = ~p1 ^ 8'h33;
      p3 = p2 ^ 8'hFF;
      ser_write(8'h0B, dir);
      bus_in = p1;
      cycles(3);
      ser_write(8'h0A, w);
      g = (w & dir) | (p1 & ~dir);
      cycles(2);
      check("R6 oe follows dir", bus_oe, dir);
      check("R6 R7 out after write", bus_out, g);
      bus_in = p2;
      cycles(3);
      g2 = (g & dir) | (p2 & ~dir);
      ser_read("R7 read captures pins", 8'h0A, g2);
      cycles(2);
      check("R7 out after read", bus_out, g2);
      bus_in = p3;
      cycles(4);
      check("R7 no capture without access", bus_out, g2);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule